// File: doc/BRIEF.md
# Large-ROM Cartridge Address Mapper

This block sits between a console's 24-bit bus address, split into an 8-bit bank and a 16-bit offset, and the memories on a large cartridge. For each strobed cycle it decides whether the access goes to the 12 MiB program ROM, to the 8 KiB battery-backed save SRAM, or to nothing at all. It then produces the linear byte offset into the chosen device.

The ROM image is assembled from several 32 KiB-per-bank windows. In every ROM window address bit 15 is ignored. Upper halves of all four bank quarters are mapped, and so are the lower halves of two bank groups. A one-bank override redirects the lower half of bank 0xC0 back to the start of the image. The two work-RAM banks are never claimed. Results are registered one cycle after a strobe and held until the next strobe.

Top module: `cart_map_decode`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, all outputs are zero.
- R2: A read with offset bit 15 set, in any bank except 0x7E/0x7F, selects ROM. The ROM offset is base + (bank − first bank of its quarter)·0x8000 + (offset & 0x7FFF). The quarters and their bases are 0x00–0x3F → 0x000000, 0x40–0x7F → 0x200000, 0x80–0xBF → 0x400000 and 0xC0–0xFF → 0x600000.
- R3: A read in banks 0x40–0x6F with offset 0x0000–0x7FFF selects ROM at 0x800000 + (bank − 0x40)·0x8000 + offset.
- R4: A read in banks 0xC1–0xFF with offset 0x0000–0x7FFF selects ROM at 0xA00000 + (bank − 0xC0)·0x8000 + offset.
- R5: A read in bank 0xC0 with offset 0x0000–0x7FFF selects ROM at the offset itself. This overrides the R4 window.
- R6: Any access to banks 0x7E or 0x7F, read or write, gives the unmapped flag, no select, no write fault and zero offsets.
- R7: A read or write in banks 0x20–0x3F or 0xA0–0xBF with offset 0x6000–0x7FFF selects SRAM with SRAM offset = offset & 0x1FFF. The same 8 KiB is seen in every such bank, and the ROM select stays low.
- R8: The SRAM write enable is high for a write that hits the SRAM window and low for a read.
- R9: A write that hits a ROM window raises no ROM select. It pulses the write-fault flag for exactly one cycle, leaves unmapped low and drives both offsets to zero.
- R10: An access covered by no window, such as the lower halves of banks 0x00–0x1F and 0x70–0x7D, gives the unmapped flag with all selects low and both offsets zero.
- R11: The ROM select asserts only inside the cartridge-enable region: banks 0x00–0x3F and 0x80–0xBF at offset 0x8000–0xFFFF, and banks 0x40–0x7D and 0xC0–0xFF at any offset.
- R12: Outputs change only on the clock edge after a strobe. With no strobe, selects, flags and offsets hold, and the write-fault flag returns low.
- R13: At most one of ROM select, SRAM select, unmapped and write fault is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bus cycle strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| bank_i | input | 8 | Bus bank |
| addr_i | input | 16 | Offset within bank |
| rom_cs_o | output | 1 | ROM select |
| rom_off_o | output | 24 | Linear ROM byte offset |
| sram_cs_o | output | 1 | SRAM select |
| sram_we_o | output | 1 | SRAM write enable |
| sram_off_o | output | 13 | SRAM byte offset |
| wr_fault_o | output | 1 | One-cycle flag for a write into ROM |
| unmapped_o | output | 1 | Cycle matched no window |

## Verification
Every cycle, the assertions check four things. The selects and flags stay mutually exclusive. Work-RAM banks and cycles outside the cartridge-enable region never raise a ROM select. Outputs hold between strobes and the write-fault pulse lasts one cycle. Unmapped results carry zero offsets. The exact ROM offsets can only be shown by the bench's full sweep against an arithmetic model. That covers every bank's edges, the bank 0xC0 override, the quarter bases and SRAM mirroring.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int BANK_W  = 8;
  localparam int OFS_W   = 16;
  localparam int ROM_AW  = 24;
  localparam int SRAM_AW = 13;
  localparam int PAGE_W  = OFS_W - 1;
  localparam int QSEL_W  = 2;
  localparam int QUAD_N  = 1 << QSEL_W;
  localparam int QIDX_W  = BANK_W - QSEL_W;

  localparam logic [BANK_W-1:0] WRAM_LO_BANK = 8'h7E;
  localparam logic [BANK_W-1:0] OVR_BANK     = 8'hC0;
  localparam logic [BANK_W-1:0] LOB_FIRST    = 8'h40;
  localparam logic [BANK_W-1:0] LOB_LAST     = 8'h6F;
  localparam logic [BANK_W-1:0] LOC_FIRST    = 8'hC0;

  localparam logic [ROM_AW-1:0] QUAD_SPAN = 24'h200000;
  localparam logic [ROM_AW-1:0] LOB_BASE  = 24'h800000;
  localparam logic [ROM_AW-1:0] LOC_BASE  = 24'hA00000;
  localparam logic [ROM_AW-1:0] OVR_BASE  = 24'h000000;

  typedef enum logic [1:0] {
    HIT_NONE  = 2'd0,
    HIT_SRAM  = 2'd1,
    HIT_ROM   = 2'd2,
    HIT_FAULT = 2'd3
  } hit_e;
endpackage

// File: rtl/cart_rom_window.sv
module cart_rom_window
  import cart_map_pkg::*;
(
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  addr_i,
  output logic              hit_o,
  output logic [ROM_AW-1:0] off_o
);
  logic [QIDX_W+PAGE_W-1:0] page_off;
  logic [QUAD_N-1:0]        hi_hit;
  logic [ROM_AW-1:0]        hi_off [QUAD_N];
  logic                     is_wram;

  assign page_off = {bank_i[QIDX_W-1:0], addr_i[PAGE_W-1:0]};
  assign is_wram  = (bank_i[BANK_W-1:1] == WRAM_LO_BANK[BANK_W-1:1]);

  // upper-half windows, one per bank quarter
  for (genvar q = 0; q < QUAD_N; q++) begin : g_quad
    localparam logic [ROM_AW-1:0] QBASE = ROM_AW'(q) * QUAD_SPAN;
    assign hi_hit[q] = addr_i[OFS_W-1] && (bank_i[BANK_W-1 -: QSEL_W] == QSEL_W'(q));
    assign hi_off[q] = QBASE + ROM_AW'(page_off);
  end

  always_comb begin
    hit_o = 1'b0;
    off_o = '0;
    if (is_wram) begin
      hit_o = 1'b0;
    end else if (addr_i[OFS_W-1]) begin
      hit_o = 1'b1;
      for (int q = 0; q < QUAD_N; q++)
        if (hi_hit[q]) off_o = hi_off[q];
    end else if (bank_i == OVR_BANK) begin
      hit_o = 1'b1;
      off_o = OVR_BASE + ROM_AW'(addr_i[PAGE_W-1:0]);
    end else if (bank_i >= LOC_FIRST) begin
      hit_o = 1'b1;
      off_o = LOC_BASE + ROM_AW'(page_off);
    end else if (bank_i >= LOB_FIRST && bank_i <= LOB_LAST) begin
      hit_o = 1'b1;
      off_o = LOB_BASE + ROM_AW'(page_off);
    end
  end
endmodule

// File: rtl/cart_sram_window.sv
module cart_sram_window
  import cart_map_pkg::*;
(
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [OFS_W-1:0]   addr_i,
  output logic               hit_o,
  output logic [SRAM_AW-1:0] off_o
);
  // banks x20-x3F in both halves of the bank space, offsets 6000-7FFF
  assign hit_o = (bank_i[BANK_W-2 -: 2] == 2'b01) &&
                 (addr_i[OFS_W-1:SRAM_AW] == 3'b011);
  assign off_o = addr_i[SRAM_AW-1:0];
endmodule

// File: rtl/cart_map_decode.sv
module cart_map_decode
  import cart_map_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               wr_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [OFS_W-1:0]   addr_i,
  output logic               rom_cs_o,
  output logic [ROM_AW-1:0]  rom_off_o,
  output logic               sram_cs_o,
  output logic               sram_we_o,
  output logic [SRAM_AW-1:0] sram_off_o,
  output logic               wr_fault_o,
  output logic               unmapped_o
);
  logic               rom_hit, sram_hit;
  logic [ROM_AW-1:0]  rom_off;
  logic [SRAM_AW-1:0] sram_off;
  hit_e               cls;

  cart_rom_window u_rom (
    .bank_i(bank_i), .addr_i(addr_i), .hit_o(rom_hit), .off_o(rom_off)
  );
  cart_sram_window u_sram (
    .bank_i(bank_i), .addr_i(addr_i), .hit_o(sram_hit), .off_o(sram_off)
  );

  // SRAM ahead of ROM; work-RAM exclusion already inside the ROM window
  always_comb begin
    if (sram_hit)     cls = HIT_SRAM;
    else if (rom_hit) cls = wr_i ? HIT_FAULT : HIT_ROM;
    else              cls = HIT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_cs_o   <= 1'b0;
      rom_off_o  <= '0;
      sram_cs_o  <= 1'b0;
      sram_we_o  <= 1'b0;
      sram_off_o <= '0;
      wr_fault_o <= 1'b0;
      unmapped_o <= 1'b0;
    end else begin
      wr_fault_o <= valid_i && (cls == HIT_FAULT);
      if (valid_i) begin
        rom_cs_o   <= (cls == HIT_ROM);
        rom_off_o  <= (cls == HIT_ROM) ? rom_off : '0;
        sram_cs_o  <= (cls == HIT_SRAM);
        sram_we_o  <= (cls == HIT_SRAM) && wr_i;
        sram_off_o <= (cls == HIT_SRAM) ? sram_off : '0;
        unmapped_o <= (cls == HIT_NONE);
      end
    end
  end

  // independent cartridge-enable decode for checking
  logic cart_en;
  assign cart_en = ((bank_i < 8'h40 || (bank_i >= 8'h80 && bank_i < 8'hC0)) && addr_i >= 16'h8000)
                 || (bank_i >= 8'h40 && bank_i <= 8'h7D) || (bank_i >= 8'hC0);

  // R13
  excl_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_cs_o, sram_cs_o, unmapped_o, wr_fault_o}));
  // R6
  wram_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (bank_i == 8'h7E || bank_i == 8'h7F) |=>
      unmapped_o && !rom_cs_o && !sram_cs_o && !wr_fault_o);
  // R11
  cart_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !cart_en |=> !rom_cs_o);
  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(rom_cs_o) && $stable(sram_cs_o) && $stable(unmapped_o)
      && $stable(rom_off_o) && $stable(sram_off_o) && $stable(sram_we_o) && !wr_fault_o);
  // R8
  we_in_sram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> sram_cs_o);
  // R10
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> (rom_off_o == '0) && (sram_off_o == '0));
  // R7
  sram_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (bank_i[6:5] == 2'b01) && (addr_i >= 16'h6000) && (addr_i < 16'h8000) |=>
      sram_cs_o && !rom_cs_o && (sram_off_o == $past(addr_i[SRAM_AW-1:0])));
  // R9
  rom_wr_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wr_i && addr_i[15] && (bank_i[7:1] != 7'h3F) |=>
      wr_fault_o && !rom_cs_o && !unmapped_o);
  // R5
  ovr_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wr_i && (bank_i == 8'hC0) && !addr_i[15] |=>
      rom_cs_o && (rom_off_o < 24'h008000));
endmodule

// File: tb/tb_cart_map_decode.sv
module tb_cart_map_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  bank = '0;
  logic [15:0] addr = '0;
  logic        rom_cs, sram_cs, sram_we, wr_fault, unmapped;
  logic [23:0] rom_off;
  logic [12:0] sram_off;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cart_map_decode dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .wr_i(wr),
    .bank_i(bank), .addr_i(addr),
    .rom_cs_o(rom_cs), .rom_off_o(rom_off), .sram_cs_o(sram_cs),
    .sram_we_o(sram_we), .sram_off_o(sram_off), .wr_fault_o(wr_fault),
    .unmapped_o(unmapped)
  );

  function automatic logic [41:0] pack_out();
    return {rom_cs, sram_cs, sram_we, wr_fault, unmapped, rom_off, sram_off};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s bank=%02h addr=%04h wr=%0d act=%h exp=%h", tag, bank, addr, wr, act, exp);
    end
  endtask

  // arithmetic reference model
  task automatic model(int b, int a, bit w, output logic [41:0] exp, output string tag);
    int kind;          // 0 none, 1 sram, 2 rom
    int off;
    kind = 0; off = 0; tag = "R10";
    if (b == 'h7E || b == 'h7F) begin
      tag = "R6";
    end else if (((b >= 'h20 && b <= 'h3F) || (b >= 'hA0 && b <= 'hBF)) && a >= 'h6000 && a <= 'h7FFF) begin
      kind = 1; off = a - 'h6000; tag = w ? "R8" : "R7";
    end else if (a >= 'h8000) begin
      kind = 2; tag = "R2";
      off = (b / 'h40) * 'h200000 + (b % 'h40) * 'h8000 + (a - 'h8000);
    end else if (b == 'hC0) begin
      kind = 2; off = a; tag = "R5";
    end else if (b >= 'h40 && b <= 'h6F) begin
      kind = 2; off = 'h800000 + (b - 'h40) * 'h8000 + a; tag = "R3";
    end else if (b >= 'hC1) begin
      kind = 2; off = 'hA00000 + (b - 'hC0) * 'h8000 + a; tag = "R4";
    end
    exp = '0;
    if (kind == 1) begin
      exp[40] = 1'b1; exp[39] = w; exp[12:0] = 13'(off);
    end else if (kind == 2 && w) begin
      exp[38] = 1'b1; tag = "R9";
    end else if (kind == 2) begin
      exp[41] = 1'b1; exp[36:13] = 24'(off);
    end else begin
      exp[37] = 1'b1;
    end
  endtask

  function automatic bit cart_region(int b, int a);
    return ((b <= 'h3F || (b >= 'h80 && b <= 'hBF)) && a >= 'h8000) ||
           (b >= 'h40 && b <= 'h7D) || (b >= 'hC0);
  endfunction

  task automatic run_one(int b, int a, bit w);
    logic [41:0] exp, got;
    string tag;
    model(b, a, w, exp, tag);
    @(negedge clk);
    bank = 8'(b); addr = 16'(a); wr = w; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    got = pack_out();
    chk(got == exp, tag, 64'(got), 64'(exp));
    chk(!rom_cs || cart_region(b, a), "R11", 64'(rom_cs), 64'(0));
    chk($countones({rom_cs, sram_cs, unmapped, wr_fault}) <= 1, "R13", 64'(got[41:37]), 64'(0));
    @(negedge clk);
    exp[38] = 1'b0;   // fault pulse is gone, everything else held
    chk(pack_out() == exp, "R12", 64'(pack_out()), 64'(exp));
  endtask

  initial begin
    int addrs [9] = '{'h0000, 'h1234, 'h5FFF, 'h6000, 'h6ABC, 'h7FFF, 'h8000, 'hC321, 'hFFFF};
    repeat (3) @(negedge clk);
    chk(pack_out() == '0, "R1", 64'(pack_out()), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(pack_out() == '0, "R1", 64'(pack_out()), 64'(0));
    for (int b = 0; b < 256; b++)
      for (int i = 0; i < 9; i++)
        for (int w = 0; w < 2; w++)
          run_one(b, addrs[i], 1'(w));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule